// File: doc/BRIEF.md
# Cartridge ROM/RAM bank controller

This block sits between an 8-bit processor bus and a cartridge's banked ROM and external RAM. The bus has a 16-bit address, a write strobe and write data. Writes into the ROM address space do not reach the ROM. The block decodes them into its control registers instead: a RAM/clock access key, a ROM bank number, a selector for the RAM bank or clock register, and a two-step latch command for the clock registers.

For every bus address the block registers a physical ROM address, a physical RAM address, a RAM write enable and two chip selects. It also steers the read data back to the processor. The lower 16 KiB window always maps ROM bank 0. The upper 16 KiB window maps the selected bank. The 8 KiB window at 0xA000 reaches one of several RAM banks, or one of a small file of latched clock registers. Reads from any region that is disabled or has nothing behind it return 0xFF.

The number of ROM banks, the number of RAM banks, the clock register count, RAM presence and timer presence are all parameters. The clock counting itself and the memories stay outside the block.

Top module: `cbc_bank_ctrl`

## Requirements
- R1: A read of 0x0000–0x3FFF drives rom_addr to the bus address bits [13:0] with bank bits zero, and returns ROM data.
- R2: A read of 0x4000–0x7FFF drives rom_addr to bank × 0x4000 + address bits [13:0], where bank is the current ROM bank register.
- R3: A write to 0x2000–0x3FFF stores the written byte as the ROM bank. The value 0 becomes 1, and any value above ROM_BANKS−1 becomes ROM_BANKS−1.
- R4: A write of 0x0A to 0x0000–0x1FFF enables RAM and clock access. Any other byte written there, 0x00 included, disables it.
- R5: A write to 0x4000–0x5FFF of a value below RAM_BANKS selects that RAM bank. With a timer present, a value from 0x08 to 0x08+CLK_REGS−1 selects clock register (value−0x08). Any other value leaves the selection unchanged.
- R6: In the window 0xA000–0xBFFF, ram_addr is (address − 0xA000) + 0x2000 × RAM bank, so each bank holds its own data.
- R7: Reads return 0xFF in three cases: the RAM window while access is disabled or RAM is absent, 0x8000–0x9FFF, and 0xC000–0xFFFF.
- R8: When a clock register is selected and access is enabled, window writes go to that live register and window reads return its latched copy. A write of 0x00 and then 0x01 to 0x6000–0x7FFF copies all live values into the latched copies. A 0x01 that does not follow 0x00 does nothing.
- R9: ram_we is raised only for a window write with RAM present, access enabled and a RAM bank selected. Writes made while access is disabled or a clock register is selected leave RAM unchanged.
- R10: After reset the ROM bank is 1, RAM bank 0 is selected and access is disabled.
- R11: rom_addr, ram_addr, ram_we, rom_cs and ram_cs are registered and follow the bus address one clock later. rom_cs is high for 0x0000–0x7FFF, and ram_cs is high for an enabled RAM window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Bus address |
| cpu_wr | input | 1 | Bus write strobe, one cycle per write |
| cpu_wdata | input | 8 | Bus write data |
| cpu_rdata | output | 8 | Read data for the address of the previous cycle |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_rdata | input | 8 | ROM data for rom_addr |
| rom_cs | output | 1 | ROM chip select |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_rdata | input | 8 | RAM data for ram_addr |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |

## Verification
Clock-register access is the hardest state to reach from the ports. It needs the access key, a selector value in the clock range, a write into the window, and then a two-write latch sequence, all in that order. The stimulus walks that sequence and reads back both before and after the latch. It also sends a lone 0x01 latch command and checks that the read value does not move. After that it switches back to a RAM bank and reads the same window offset, which shows that the clock-register write never reached RAM.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_CLK  = 2'd3
  } rd_src_e;

  // Control write regions, decoded from address bits [15:13]
  localparam logic [2:0] REG_ENABLE = 3'b000;
  localparam logic [2:0] REG_ROMSEL = 3'b001;
  localparam logic [2:0] REG_AUXSEL = 3'b010;
  localparam logic [2:0] REG_LATCH  = 3'b011;
  localparam logic [2:0] WIN_EXTRAM = 3'b101;

  localparam logic [7:0] ACCESS_KEY = 8'h0A;
  localparam logic [7:0] CLK_BASE   = 8'h08;

endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 128,
  parameter int RAM_BANKS = 4,
  parameter int CLK_REGS  = 5,
  parameter bit HAS_TIMER = 1'b1,
  parameter int BANK_W    = $clog2(ROM_BANKS),
  parameter int RB_W      = $clog2(RAM_BANKS),
  parameter int CI_W      = $clog2(CLK_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        region,
  input  logic [7:0]        wdata,
  output logic              en_q,
  output logic [BANK_W-1:0] rom_bank_q,
  output logic [RB_W-1:0]   ram_bank_q,
  output logic              sel_clk_q,
  output logic [CI_W-1:0]   clk_idx_q,
  output logic              latch_o
);

  localparam logic [7:0] LAST8 = 8'(ROM_BANKS - 1);

  logic [7:0] bank_nx;
  logic       ram_hit;
  logic       clk_hit;
  logic       armed_q;

  always_comb begin
    if (wdata > LAST8)       bank_nx = LAST8;
    else if (wdata == 8'h00) bank_nx = 8'h01;
    else                     bank_nx = wdata;
  end

  assign ram_hit = (wdata < 8'(RAM_BANKS));
  assign clk_hit = HAS_TIMER && (wdata >= CLK_BASE) && (wdata < CLK_BASE + 8'(CLK_REGS));
  assign latch_o = wr && (region == REG_LATCH) && armed_q && (wdata == 8'h01);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      rom_bank_q <= BANK_W'(1);
      ram_bank_q <= '0;
      sel_clk_q  <= 1'b0;
      clk_idx_q  <= '0;
      armed_q    <= 1'b0;
    end else if (wr) begin
      case (region)
        REG_ENABLE: en_q <= (wdata == ACCESS_KEY);
        REG_ROMSEL: rom_bank_q <= BANK_W'(bank_nx);
        REG_AUXSEL: begin
          if (ram_hit) begin
            sel_clk_q  <= 1'b0;
            ram_bank_q <= RB_W'(wdata);
          end else if (clk_hit) begin
            sel_clk_q <= 1'b1;
            clk_idx_q <= CI_W'(wdata - CLK_BASE);
          end
        end
        REG_LATCH: armed_q <= (wdata == 8'h00);
        default: ;
      endcase
    end
  end

  // R3: bank register never holds 0 and never exceeds the last bank
  p_bank_range_r3: assert property (@(posedge clk) disable iff (rst)
    (rom_bank_q != '0) && (32'(rom_bank_q) <= ROM_BANKS - 1));

  // R3: oversized bank values clamp to the last bank
  p_bank_clamp_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && region == REG_ROMSEL && wdata > LAST8) |=> (rom_bank_q == BANK_W'(ROM_BANKS - 1)));

  // R4: only the key value enables access
  p_access_key_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && region == REG_ENABLE) |=> (en_q == ($past(wdata) == ACCESS_KEY)));

  // R5: selector values outside both ranges change nothing
  p_sel_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && region == REG_AUXSEL && !ram_hit && !clk_hit) |=> ($stable(ram_bank_q) && $stable(sel_clk_q)));

endmodule

// File: rtl/cbc_clk_file.sv
module cbc_clk_file #(
  parameter int CLK_REGS = 5,
  parameter int CI_W     = $clog2(CLK_REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CI_W-1:0] idx,
  input  logic [7:0]      wdata,
  input  logic            latch,
  output logic [7:0]      rd_q
);

  logic [7:0] live_q [CLK_REGS];
  logic [7:0] lat_q  [CLK_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CLK_REGS; i++) begin
        live_q[i] <= 8'h00;
        lat_q[i]  <= 8'h00;
      end
      rd_q <= 8'h00;
    end else begin
      if (wr_en) live_q[idx] <= wdata;
      if (latch) begin
        for (int i = 0; i < CLK_REGS; i++) lat_q[i] <= live_q[i];
      end
      rd_q <= lat_q[idx];
    end
  end

  for (genvar g = 0; g < CLK_REGS; g++) begin : g_chk
    // R8: latched copies move only on a latch command
    p_lat_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !latch |=> $stable(lat_q[g]));
    // R8: a latch command captures the live value
    p_lat_copy_r8: assert property (@(posedge clk) disable iff (rst)
      latch |=> (lat_q[g] == $past(live_q[g])));
  end

endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map
  import cbc_pkg::*;
#(
  parameter bit HAS_RAM   = 1'b1,
  parameter bit HAS_TIMER = 1'b1,
  parameter int BANK_W    = 7,
  parameter int RB_W      = 2,
  parameter int ROM_AW    = BANK_W + 14,
  parameter int RAM_AW    = RB_W + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic              en,
  input  logic [BANK_W-1:0] rom_bank,
  input  logic [RB_W-1:0]   ram_bank,
  input  logic              sel_clk,
  output logic [ROM_AW-1:0] rom_addr_q,
  output logic [RAM_AW-1:0] ram_addr_q,
  output logic              ram_we_q,
  output logic [7:0]        ram_wdata_q,
  output rd_src_e           src_q,
  output logic              clk_wr_o
);

  logic    in_win;
  logic    ram_ok;
  logic    clk_ok;
  rd_src_e src_nx;

  assign in_win   = (addr[15:13] == WIN_EXTRAM);
  assign ram_ok   = HAS_RAM && en && !sel_clk;
  assign clk_ok   = HAS_TIMER && en && sel_clk;
  assign clk_wr_o = wr && in_win && clk_ok;

  always_comb begin
    if (!addr[15])             src_nx = SRC_ROM;
    else if (in_win && ram_ok) src_nx = SRC_RAM;
    else if (in_win && clk_ok) src_nx = SRC_CLK;
    else                       src_nx = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr_q  <= '0;
      ram_addr_q  <= '0;
      ram_we_q    <= 1'b0;
      ram_wdata_q <= 8'h00;
      src_q       <= SRC_NONE;
    end else begin
      rom_addr_q  <= addr[14] ? {rom_bank, addr[13:0]} : {{BANK_W{1'b0}}, addr[13:0]};
      ram_addr_q  <= {ram_bank, addr[12:0]};
      ram_we_q    <= wr && in_win && ram_ok;
      ram_wdata_q <= wdata;
      src_q       <= src_nx;
    end
  end

endmodule

// File: rtl/cbc_bank_ctrl.sv
module cbc_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS   = 128,
  parameter int RAM_BANKS   = 4,
  parameter int CLK_REGS    = 5,
  parameter bit HAS_RAM     = 1'b1,
  parameter bit HAS_TIMER   = 1'b1,
  localparam int BANK_W     = $clog2(ROM_BANKS),
  localparam int RB_W       = $clog2(RAM_BANKS),
  localparam int CI_W       = $clog2(CLK_REGS),
  localparam int ROM_AW     = BANK_W + 14,
  localparam int RAM_AW     = RB_W + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic              rom_cs,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic [7:0]        ram_rdata,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [7:0]        ram_wdata
);

  logic              en;
  logic [BANK_W-1:0] rom_bank;
  logic [RB_W-1:0]   ram_bank;
  logic              sel_clk;
  logic [CI_W-1:0]   clk_idx;
  logic              latch;
  logic              clk_wr;
  logic [7:0]        clk_rd;
  rd_src_e           src;

  cbc_ctrl_regs #(
    .ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS), .CLK_REGS(CLK_REGS),
    .HAS_TIMER(HAS_TIMER), .BANK_W(BANK_W), .RB_W(RB_W), .CI_W(CI_W)
  ) i_regs (
    .clk(clk), .rst(rst), .wr(cpu_wr), .region(cpu_addr[15:13]), .wdata(cpu_wdata),
    .en_q(en), .rom_bank_q(rom_bank), .ram_bank_q(ram_bank),
    .sel_clk_q(sel_clk), .clk_idx_q(clk_idx), .latch_o(latch)
  );

  cbc_addr_map #(
    .HAS_RAM(HAS_RAM), .HAS_TIMER(HAS_TIMER), .BANK_W(BANK_W), .RB_W(RB_W),
    .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)
  ) i_map (
    .clk(clk), .rst(rst), .addr(cpu_addr), .wr(cpu_wr), .wdata(cpu_wdata),
    .en(en), .rom_bank(rom_bank), .ram_bank(ram_bank), .sel_clk(sel_clk),
    .rom_addr_q(rom_addr), .ram_addr_q(ram_addr), .ram_we_q(ram_we),
    .ram_wdata_q(ram_wdata), .src_q(src), .clk_wr_o(clk_wr)
  );

  cbc_clk_file #(.CLK_REGS(CLK_REGS), .CI_W(CI_W)) i_clk (
    .clk(clk), .rst(rst), .wr_en(clk_wr), .idx(clk_idx), .wdata(cpu_wdata),
    .latch(latch), .rd_q(clk_rd)
  );

  assign rom_cs = (src == SRC_ROM);
  assign ram_cs = (src == SRC_RAM);

  always_comb begin
    case (src)
      SRC_ROM: cpu_rdata = rom_rdata;
      SRC_RAM: cpu_rdata = ram_rdata;
      SRC_CLK: cpu_rdata = clk_rd;
      default: cpu_rdata = 8'hFF;
    endcase
  end

  // R1: fixed window always lands in bank 0 at the same offset
  p_bank0_map_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b00) |=> (rom_addr == ROM_AW'($past(cpu_addr[13:0]))));

  // R2: switchable window never lands in bank 0
  p_upper_bank_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b01) |=> (rom_addr[ROM_AW-1:14] != '0));

  // R9: RAM write enable only follows an enabled window write
  p_we_gated_r9: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(cpu_wr) && ($past(cpu_addr[15:13]) == WIN_EXTRAM) && $past(en)));

  // R7: disabled window reads as 0xFF
  p_off_ff_r7: assert property (@(posedge clk) disable iff (rst)
    ((cpu_addr[15:13] == WIN_EXTRAM) && !en) |=> (cpu_rdata == 8'hFF));

endmodule

// File: tb/test_cbc_bank_ctrl.sv
module test_cbc_bank_ctrl;

  localparam int ROM_AW = 21;
  localparam int RAM_AW = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       cpu_addr = 16'h0000;
  logic              cpu_wr = 1'b0;
  logic [7:0]        cpu_wdata = 8'h00;
  logic [7:0]        cpu_rdata;
  logic [ROM_AW-1:0] rom_addr;
  logic [7:0]        rom_rdata;
  logic              rom_cs;
  logic [RAM_AW-1:0] ram_addr;
  logic [7:0]        ram_rdata;
  logic              ram_cs;
  logic              ram_we;
  logic [7:0]        ram_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cbc_bank_ctrl i_cbc_bank_ctrl (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata), .rom_cs(rom_cs),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_wdata(ram_wdata)
  );

  // ROM model: byte = low address byte XOR bank number
  function automatic logic [7:0] rom_fn(input logic [6:0] bank, input logic [13:0] off);
    return off[7:0] ^ {1'b0, bank};
  endfunction
  assign rom_rdata = rom_fn(rom_addr[20:14], rom_addr[13:0]);

  // Small RAM model indexed by bank and low four offset bits
  logic [7:0] ram_m [64];
  initial for (int i = 0; i < 64; i++) ram_m[i] = 8'h00;
  always @(posedge clk) if (ram_we) ram_m[{ram_addr[14:13], ram_addr[3:0]}] <= ram_wdata;
  assign ram_rdata = ram_m[{ram_addr[14:13], ram_addr[3:0]}];

  // {kind, req, addr, data, exp}; kind 1 write, 2 ROM read (data = bank), 3 exact read
  localparam int NV = 34;
  localparam logic [39:0] VEC [NV] = '{
    {4'd2, 4'd1,  16'h0000, 8'h00, 8'h00},  // R1
    {4'd2, 4'd1,  16'h3FFF, 8'h00, 8'h00},  // R1
    {4'd2, 4'd10, 16'h4000, 8'h01, 8'h00},  // R10 reset bank
    {4'd1, 4'd3,  16'h2000, 8'h05, 8'h00},
    {4'd2, 4'd2,  16'h4123, 8'h05, 8'h00},  // R2
    {4'd2, 4'd1,  16'h1234, 8'h00, 8'h00},  // R1
    {4'd1, 4'd3,  16'h3FFF, 8'h00, 8'h00},
    {4'd2, 4'd3,  16'h7FFF, 8'h01, 8'h00},  // R3 zero -> 1
    {4'd1, 4'd3,  16'h2000, 8'hFF, 8'h00},
    {4'd2, 4'd3,  16'h4010, 8'h7F, 8'h00},  // R3 clamp
    {4'd1, 4'd3,  16'h2000, 8'h7E, 8'h00},
    {4'd2, 4'd3,  16'h5555, 8'h7E, 8'h00},  // R3 in range
    {4'd3, 4'd7,  16'hA000, 8'h00, 8'hFF},  // R7 disabled
    {4'd3, 4'd7,  16'h8000, 8'h00, 8'hFF},  // R7 unmapped
    {4'd3, 4'd7,  16'hC000, 8'h00, 8'hFF},  // R7
    {4'd3, 4'd7,  16'hFFFF, 8'h00, 8'hFF},  // R7
    {4'd1, 4'd4,  16'h0000, 8'h0A, 8'h00},
    {4'd1, 4'd6,  16'hA003, 8'h5A, 8'h00},
    {4'd3, 4'd6,  16'hA003, 8'h00, 8'h5A},  // R6 bank 0
    {4'd1, 4'd5,  16'h4000, 8'h02, 8'h00},
    {4'd1, 4'd6,  16'hA003, 8'hC3, 8'h00},
    {4'd3, 4'd6,  16'hA003, 8'h00, 8'hC3},  // R6 bank 2
    {4'd1, 4'd5,  16'h4000, 8'h05, 8'h00},
    {4'd3, 4'd5,  16'hA003, 8'h00, 8'hC3},  // R5 ignored value
    {4'd1, 4'd5,  16'h4000, 8'h00, 8'h00},
    {4'd3, 4'd6,  16'hA003, 8'h00, 8'h5A},  // R6 back to bank 0
    {4'd1, 4'd4,  16'h1000, 8'h00, 8'h00},
    {4'd3, 4'd4,  16'hA003, 8'h00, 8'hFF},  // R4 0x00 disables
    {4'd1, 4'd9,  16'hA003, 8'h11, 8'h00},
    {4'd1, 4'd4,  16'h0000, 8'h0A, 8'h00},
    {4'd3, 4'd9,  16'hA003, 8'h00, 8'h5A},  // R9 disabled write dropped
    {4'd1, 4'd4,  16'h1FFF, 8'h0B, 8'h00},
    {4'd3, 4'd4,  16'hA003, 8'h00, 8'hFF},  // R4 other value disables
    {4'd1, 4'd4,  16'h0000, 8'h0A, 8'h00}
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    apply_reset();

    // R10: reset state seen at the ports
    bus_read(16'h4000, rd);
    check8("R10 reset rom bank", rd, rom_fn(7'd1, 14'h0000));
    bus_read(16'hA000, rd);
    check8("R10 reset access off", rd, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  kind;
      logic [3:0]  req;
      logic [15:0] a;
      logic [7:0]  d;
      logic [7:0]  e;
      string       tag;
      {kind, req, a, d, e} = VEC[i];
      tag = $sformatf("R%0d vec%0d", req, i);
      if (kind == 4'd1) bus_write(a, d);
      else begin
        bus_read(a, rd);
        if (kind == 4'd2) check8(tag, rd, rom_fn(d[6:0], a[13:0]));
        else              check8(tag, rd, e);
      end
    end

    // R11: chip selects and registered addresses
    @(negedge clk); cpu_addr = 16'h4ABC;
    @(negedge clk);
    check8("R11 rom_cs upper", {7'd0, rom_cs}, 8'h01);
    check8("R11 rom_addr low", rom_addr[7:0], 8'hBC);
    check8("R2 rom_addr bank", {1'b0, rom_addr[20:14]}, 8'h7E);
    @(negedge clk); cpu_addr = 16'hA003;
    @(negedge clk);
    check8("R11 ram_cs window", {6'd0, ram_cs, rom_cs}, 8'h02);
    check8("R6 ram_addr offset", ram_addr[7:0], 8'h03);
    @(negedge clk); cpu_addr = 16'h9000;
    @(negedge clk);
    check8("R11 no select", {6'd0, ram_cs, rom_cs}, 8'h00);

    // R8: clock registers, latch sequence, isolation from RAM
    bus_write(16'hA000, 8'h44);
    bus_write(16'h4000, 8'h08);
    bus_write(16'hA000, 8'h2A);
    bus_read(16'hA000, rd);
    check8("R8 before latch", rd, 8'h00);
    bus_write(16'h6000, 8'h00);
    bus_write(16'h6000, 8'h01);
    bus_read(16'hA000, rd);
    check8("R8 after latch", rd, 8'h2A);
    bus_write(16'h4000, 8'h0C);
    bus_write(16'hA000, 8'h99);
    bus_write(16'h6000, 8'h01);
    bus_read(16'hA000, rd);
    check8("R8 lone 0x01 no latch", rd, 8'h00);
    bus_write(16'h6000, 8'h00);
    bus_write(16'h6000, 8'h01);
    bus_read(16'hBFFF, rd);
    check8("R8 reg4 latched", rd, 8'h99);
    bus_write(16'h4000, 8'h08);
    bus_read(16'hA000, rd);
    check8("R8 reg0 kept", rd, 8'h2A);
    bus_write(16'h4000, 8'h00);
    bus_read(16'hA000, rd);
    check8("R9 clock write kept off RAM", rd, 8'h44);

    // R10: mid-run reset restores defaults
    bus_write(16'h2000, 8'h33);
    bus_write(16'h4000, 8'h02);
    apply_reset();
    bus_read(16'h4007, rd);
    check8("R10 bank back to 1", rd, rom_fn(7'd1, 14'h0007));
    bus_read(16'hA003, rd);
    check8("R10 access off", rd, 8'hFF);
    bus_write(16'h0000, 8'h0A);
    bus_read(16'hA003, rd);
    check8("R10 ram bank 0", rd, 8'h5A);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule